// File: doc/BRIEF.md
# Codec Power-State Controller

This block decides whether a PCM voice codec is powered and whether its serial transmit data output may leave high impedance. It watches three asynchronous pins: a shared master-clock/power-down pin, the transmit frame sync and the receive frame sync. It samples them with a free-running reference clock and produces two flags: a powered flag for the converter circuits and a permit flag for the enable of the tri-state transmit data buffer.

The shared pin has three readings. A steady low level means "run". A toggling clock means "run". A high level with no edge for a short window means "power down". Frame-sync activity acts as a second power control. A wake-up needs a frame-sync rising edge while the pin allows running. If no frame-sync rising edge is seen on either sync pin for a programmable time (1 ms by default), the block falls back to the powered-down state. The reset state behaves like that idle condition. After every wake-up the transmit buffer is kept off until the second transmit frame-sync edge of the new powered period, so that stale conversion data never reaches the bus.

Top module: `codec_pwr_ctl`

## Requirements
- R1: After reset is released, and before any frame-sync edge, `powered` and `txPermit` are both 0.
- R2: Once the master-clock/power-down pin has been high with no edge for CLK_WIN reference cycles, `powered` goes to 0, and frame-sync edges do not raise it while the pin stays that way.
- R3: While powered down, with the pin held low or toggling, `powered` stays 0 until a rising edge on either frame sync (transmit or receive). After that edge it becomes 1.
- R4: If the frame-sync rising edge captured at reference edge k is the last one, `powered` is still 1 after edge k+IDLE_CYC and is 0 after edge k+IDLE_CYC+3. IDLE_CYC is CLK_HZ/1e6 × IDLE_US. A later frame-sync edge powers the block up again.
- R5: `txPermit` rises only on the second transmit frame-sync rising edge counted from the wake-up. The edge that caused the wake-up counts if it was a transmit sync. Receive frame-sync edges never advance the count.
- R6: `txPermit` is never 1 while `powered` is 0. It drops together with `powered`.
- R7: A pin toggling faster than once per CLK_WIN reference cycles is treated as a running clock. It keeps the block powered even though the pin is high half of the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low power-on reset |
| mclkPdnPin | input | 1 | Shared master-clock / power-down pin (asynchronous) |
| fsxPin | input | 1 | Transmit frame sync (asynchronous) |
| fsrPin | input | 1 | Receive frame sync (asynchronous) |
| powered | output | 1 | Codec circuits powered |
| txPermit | output | 1 | Transmit data buffer may drive |

## Verification
The hardest situation to reach from the ports is the exact cycle on which sync inactivity expires. The expiry depends on the last frame-sync edge passing through a two-flop synchronizer and an edge detector before the idle counter reloads. The bench uses a small idle time of 100 reference cycles. It raises the transmit sync on a known edge, counts reference edges from there, and samples one cycle inside and one cycle outside the computed boundary. A second hard case is a pin that toggles, which is high half of the time but must still count as "run". A background process drives the pin as a slow clock while the frame-sync sweeps run.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_ARMED = 2'd1,
    PS_LIVE  = 2'd2
  } pwrState_t;

  // strobes from control to the datapath's transmit-sync counter
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntStrobe_t;

endpackage

// File: rtl/codec_pwr_sync.sv
module codec_pwr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= {STAGES{RST_VAL}};
    else       shiftQ <= {shiftQ[STAGES-2:0], d};
  end

  assign q = shiftQ[STAGES-1];
endmodule

// File: rtl/codec_pwr_dp.sv
module codec_pwr_dp
  import codec_pwr_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int IDLE_US      = 1000,
  parameter int CLK_WIN      = 8,
  parameter int PERMIT_EDGES = 2,
  parameter int SYNC_STAGES  = 2,
  localparam int IDLE_CYC    = (CLK_HZ / 1_000_000) * IDLE_US,
  localparam int IW          = $clog2(IDLE_CYC + 1),
  localparam int WW          = $clog2(CLK_WIN + 1),
  localparam int FCW         = $clog2(PERMIT_EDGES + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           mclkPdnPin,
  input  logic           fsxPin,
  input  logic           fsrPin,
  input  cntStrobe_t     strobe,
  output logic           pinPdn,
  output logic           idleExpired,
  output logic           fsEdge,
  output logic           fsxEdge,
  output logic [FCW-1:0] fsxCount
);
  localparam logic [2:0] PIN_RST = 3'b001; // pin reads as power-down during reset

  logic [2:0] pinRaw;
  logic [2:0] pinSync;
  logic [2:0] pinPrev;
  assign pinRaw = {fsrPin, fsxPin, mclkPdnPin};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    codec_pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[i])) sync_i (
      .clk(clk), .rstN(rstN), .d(pinRaw[i]), .q(pinSync[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= PIN_RST;
    else       pinPrev <= pinSync;
  end

  logic mclkEdge, fsrEdge;
  assign mclkEdge = pinSync[0] ^ pinPrev[0];
  assign fsxEdge  = pinSync[1] & ~pinPrev[1];
  assign fsrEdge  = pinSync[2] & ~pinPrev[2];
  assign fsEdge   = fsxEdge | fsrEdge;

  // clock-activity window on the shared pin
  logic [WW-1:0] sinceEdge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       sinceEdge <= WW'(CLK_WIN);
    else if (mclkEdge)               sinceEdge <= '0;
    else if (sinceEdge != WW'(CLK_WIN)) sinceEdge <= sinceEdge + 1'b1;
  end

  logic clkActive;
  assign clkActive = mclkEdge || (sinceEdge != WW'(CLK_WIN));
  assign pinPdn    = pinSync[0] && !clkActive;

  // frame-sync inactivity timer; starts expired
  logic [IW-1:0] idleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idleCnt <= '0;
    else if (fsEdge)        idleCnt <= IW'(IDLE_CYC - 1);
    else if (idleCnt != '0) idleCnt <= idleCnt - 1'b1;
  end
  assign idleExpired = (idleCnt == '0) && !fsEdge;

  // transmit-sync edges since wake-up, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 fsxCount <= '0;
    else if (strobe.cntClr)    fsxCount <= strobe.cntInc ? FCW'(1) : '0;
    else if (strobe.cntInc && fsxCount != FCW'(PERMIT_EDGES))
                               fsxCount <= fsxCount + 1'b1;
  end

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    int'(fsxCount) <= PERMIT_EDGES); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!fsEdge && idleExpired) |=> idleExpired || fsEdge); // R4
endmodule

// File: rtl/codec_pwr_fsm.sv
module codec_pwr_fsm
  import codec_pwr_pkg::*;
#(
  parameter int PERMIT_EDGES = 2,
  localparam int FCW         = $clog2(PERMIT_EDGES + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pinPdn,
  input  logic           idleExpired,
  input  logic           fsEdge,
  input  logic           fsxEdge,
  input  logic [FCW-1:0] fsxCount,
  output cntStrobe_t     strobe,
  output logic           powered,
  output logic           txPermit
);
  pwrState_t stateQ, stateD;
  logic      downReq, permitHit;

  assign downReq   = pinPdn || idleExpired;
  assign permitHit = fsxEdge && (int'(fsxCount) >= PERMIT_EDGES - 1);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      PS_OFF: begin
        strobe.cntClr = 1'b1;
        if (!pinPdn && fsEdge) begin
          strobe.cntInc = fsxEdge;
          stateD = (fsxEdge && PERMIT_EDGES <= 1) ? PS_LIVE : PS_ARMED;
        end
      end
      PS_ARMED: begin
        strobe.cntInc = fsxEdge;
        if (downReq)        stateD = PS_OFF;
        else if (permitHit) stateD = PS_LIVE;
      end
      PS_LIVE: begin
        if (downReq) stateD = PS_OFF;
      end
      default: stateD = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PS_OFF;
    else       stateQ <= stateD;
  end

  assign powered  = (stateQ != PS_OFF);
  assign txPermit = (stateQ == PS_LIVE);

  AST_PIN_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    pinPdn |=> !powered); // R2
  AST_IDLE_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    idleExpired |=> !powered); // R4
  AST_WAKE_NEEDS_FS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powered) |-> $past(fsEdge)); // R3
  AST_PERMIT_NEEDS_FSX: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPermit) |-> $past(fsxEdge)); // R5
endmodule

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl
  import codec_pwr_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int IDLE_US      = 1000,
  parameter int CLK_WIN      = 8,
  parameter int PERMIT_EDGES = 2,
  parameter int SYNC_STAGES  = 2,
  localparam int FCW         = $clog2(PERMIT_EDGES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic mclkPdnPin,
  input  logic fsxPin,
  input  logic fsrPin,
  output logic powered,
  output logic txPermit
);
  cntStrobe_t     strobe;
  logic           pinPdn, idleExpired, fsEdge, fsxEdge;
  logic [FCW-1:0] fsxCount;

  codec_pwr_dp #(
    .CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US), .CLK_WIN(CLK_WIN),
    .PERMIT_EDGES(PERMIT_EDGES), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .mclkPdnPin(mclkPdnPin), .fsxPin(fsxPin),
    .fsrPin(fsrPin), .strobe(strobe), .pinPdn(pinPdn),
    .idleExpired(idleExpired), .fsEdge(fsEdge), .fsxEdge(fsxEdge),
    .fsxCount(fsxCount)
  );

  codec_pwr_fsm #(.PERMIT_EDGES(PERMIT_EDGES)) fsm_i (
    .clk(clk), .rstN(rstN), .pinPdn(pinPdn), .idleExpired(idleExpired),
    .fsEdge(fsEdge), .fsxEdge(fsxEdge), .fsxCount(fsxCount),
    .strobe(strobe), .powered(powered), .txPermit(txPermit)
  );

  AST_PERMIT_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    txPermit |-> powered); // R6
endmodule

// File: tb/codec_pwr_ctl_tb.sv
module codec_pwr_ctl_tb_top;
  localparam int CLK_HZ   = 50_000_000;
  localparam int IDLE_US  = 2;
  localparam int IDLE_CYC = (CLK_HZ / 1_000_000) * IDLE_US;
  localparam int CLK_WIN  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclkPin = 1'b1;
  logic fsxPin = 1'b0;
  logic fsrPin = 1'b0;
  logic mclkRun = 1'b0;
  logic powered, txPermit;
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  codec_pwr_ctl #(
    .CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US), .CLK_WIN(CLK_WIN),
    .PERMIT_EDGES(2), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .mclkPdnPin(mclkPin), .fsxPin(fsxPin),
    .fsrPin(fsrPin), .powered(powered), .txPermit(txPermit)
  );

  // slow clock on the shared pin: one edge every two reference cycles
  initial forever begin
    repeat (2) @(negedge clk);
    if (mclkRun) mclkPin = ~mclkPin;
  end

  task automatic check(string req, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind 0 = transmit sync, 1 = receive sync
  task automatic pulse(int kind);
    @(negedge clk);
    if (kind == 0) fsxPin = 1'b1; else fsrPin = 1'b1;
    waitN(3);
    fsxPin = 1'b0;
    fsrPin = 1'b0;
    waitN(5);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    int fsxSeen;
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    check("R1", "powered after reset", powered, 1'b0);
    check("R1", "txPermit after reset", txPermit, 1'b0);

    // R2: static high pin blocks wake-up from frame syncs
    pulse(0);
    pulse(1);
    check("R2", "powered with pin high", powered, 1'b0);

    for (int mode = 0; mode < 2; mode++) begin
      for (int wake = 0; wake < 2; wake++) begin
        if (mode == 0) mclkPin = 1'b0; else mclkRun = 1'b1;
        waitN(12);
        check("R3", "down before any sync", powered, 1'b0);
        fsxSeen = 0;
        pulse(wake);
        if (wake == 0) fsxSeen++;
        check("R3", "powered after wake edge", powered, 1'b1);
        check("R5", "permit after wake edge", txPermit, fsxSeen >= 2);
        for (int p = 0; p < 3; p++) begin
          pulse(1);
          check("R5", "receive sync leaves permit", txPermit, fsxSeen >= 2);
          pulse(0);
          fsxSeen++;
          check("R5", "permit after transmit sync", txPermit, fsxSeen >= 2);
          if (mode == 1) check("R7", "toggling pin keeps power", powered, 1'b1);
        end
        mclkRun = 1'b0;
        @(negedge clk);
        mclkPin = 1'b1;
        waitN(CLK_WIN + 12);
        check("R2", "powered after static high", powered, 1'b0);
        check("R6", "permit drops with power", txPermit, 1'b0);
        pulse(0);
        check("R2", "sync ignored while pin high", powered, 1'b0);
      end
    end

    // R4: inactivity timeout boundary
    mclkPin = 1'b0;
    waitN(4);
    pulse(0);
    pulse(0);
    check("R5", "permit before timeout test", txPermit, 1'b1);
    @(negedge clk);
    fsxPin = 1'b1;                // captured at the next rising edge k
    for (int i = 1; i <= IDLE_CYC + 1; i++) begin
      @(negedge clk);             // now after edge k+i-1
      if (i == 3) fsxPin = 1'b0;
    end
    check("R4", "still powered at k+IDLE", powered, 1'b1);
    check("R4", "still permitted at k+IDLE", txPermit, 1'b1);
    waitN(3);
    check("R4", "down at k+IDLE+3", powered, 1'b0);
    check("R6", "permit down at k+IDLE+3", txPermit, 1'b0);
    pulse(1);
    check("R4", "first sync after idle wakes", powered, 1'b1);
    check("R5", "permit held after receive wake", txPermit, 1'b0);
    summary();
  end
endmodule